// File: doc/BRIEF.md
# Reloadable Bytecode Translation Table

This block sits between a bytecode fetch stage and the native instruction decoder of a core that runs stack-machine interpreters. Each incoming 8-bit bytecode selects one table entry of four 32-bit native instruction slots. The slots are issued to decode one after another until a slot marked as the last one has gone out. A frequent bytecode is covered by a short native sequence. A complex one ends in a jump into its interpreter handler. The marker is a bit inside each stored word that decode never sees, because it is rewritten to its legal value on the way out.

The table is not fixed logic. It behaves as a tiny cache level in front of the instruction cache. Every entry has a valid flag. A lookup that finds its entry empty stalls and fetches the entry's four words from memory in one request, then issues from the filled entry. A write of the set-select register swaps the whole bytecode set: all entries become invalid, the fetch base moves, and a generation tag moves on, so that a fill answering an older request cannot load stale words. Different threads can therefore run different bytecode languages on the same core by reloading the set select when they switch.

Top module: `bytecode_xlate`

## Requirements
- R1: After reset, bc_ready is 1, ins_valid is 0, rf_req_valid is 0, the generation tag is 0, the set base is 0 and every entry is invalid.
- R2: Accepting a bytecode (bc_valid and bc_ready) whose entry is invalid raises rf_req_valid in the next cycle with rf_req_addr = {set base, bytecode, 4'b0000} and rf_req_tag equal to the current generation. No instruction is issued until the entry is filled.
- R3: While rf_req_valid is 1 and rf_req_ready is 0 and no set-select write occurs, the request stays valid with unchanged address and tag.
- R4: After the request is accepted, a response with rf_rsp_tag equal to the current generation fills the entry: slot k takes rf_rsp_data bits [32k+31:32k]. Issue starts from slot 0 in the next cycle.
- R5: Accepting a bytecode whose entry is valid raises ins_valid in the next cycle without any refill request.
- R6: Slots are issued in the order 0, 1, 2, 3, one per accepted ins_valid/ins_ready handshake. A slot whose stored bit 0 is 0 is the last of the sequence: ins_last is 1 for it, and after its handshake bc_ready is 1 in the next cycle.
- R7: If none of slots 0 to 2 has stored bit 0 equal to 0, slot 3 is the last one and carries ins_last, whatever its own bit 0.
- R8: Every issued instruction has bit 0 equal to 1.
- R9: While ins_valid is 1 and ins_ready is 0, ins_valid, ins_data and ins_last hold.
- R10: A cycle with cfg_wr=1 loads cfg_set as the new set base, advances the generation tag by 1 modulo 4 and invalidates every entry, so that later lookups miss and fetch from the new base.
- R11: A response whose tag differs from the current generation, or one that arrives in the same cycle as a set-select write, is discarded. A fill that was outstanding at the write is requested again from the new base with the new tag.
- R12: A bytecode that is already issuing, or is accepted as a hit in the same cycle as a set-select write, completes its whole sequence from the words held for it.
- R13: bc_ready is 1 only while no refill is outstanding and no sequence is issuing, and a bytecode is accepted only in a cycle with bc_valid and bc_ready both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the set-select register |
| cfg_set | input | 20 | New set base, bits 31:12 of the fetch address |
| bc_valid | input | 1 | Bytecode offered |
| bc_code | input | 8 | Bytecode value |
| bc_ready | output | 1 | Block can accept a bytecode |
| ins_valid | output | 1 | Native instruction offered to decode |
| ins_data | output | 32 | Native instruction with its marker bit restored to 1 |
| ins_last | output | 1 | This instruction ends the bytecode's sequence |
| ins_ready | input | 1 | Decode takes the instruction |
| rf_req_valid | output | 1 | Refill request valid |
| rf_req_ready | input | 1 | Memory takes the refill request |
| rf_req_addr | output | 32 | Byte address of the entry's four words |
| rf_req_tag | output | 2 | Generation the request belongs to |
| rf_rsp_valid | input | 1 | Refill data valid |
| rf_rsp_tag | input | 2 | Generation echoed with the data |
| rf_rsp_data | input | 128 | Four instruction words, slot 0 in the low bits |

## Verification
A set-select write can land in the very cycle in which a refill answer returns with the tag that was current until then. The bench provokes this by holding back the memory answer by hand, then raising cfg_wr and rf_rsp_valid together. The fill must be dropped and a new request must appear in the next cycle with the new base and the next tag. A second collision raises cfg_wr while a bytecode without any end marker is in mid-issue under back-pressure, and all four of its slots must still arrive unchanged. A behavioural reference model runs in the bench and is compared against every output on every clock, so the ordering between the invalidation and the fill or issue is judged cycle by cycle.

// File: rtl/btx_pkg.sv
// Package: shared types of the bytecode translation table.
// Assumes: nothing beyond IEEE 1800-2017.
package btx_pkg;

    // Control states of the sequencer.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // waiting for a bytecode
        ST_REQ   = 2'd1,   // refill request presented
        ST_WAIT  = 2'd2,   // refill request accepted, waiting for data
        ST_ISSUE = 2'd3    // issuing slots of the current entry
    } btx_state_e;

endpackage

// File: rtl/btx_store.sv
// Module: btx_store
// Holds one line of SLOTS instruction words per bytecode value plus a
// valid flag per line. The read is combinational on index and slot. A
// clear drops every valid flag and wins over a fill in the same cycle.
// Assumes: SLOTS is a power of two and at least 2.
module btx_store #(
    parameter int BC_W  = 8,
    parameter int SLOTS = 4,
    parameter int INS_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr_all,
    input  logic                      fill_en,
    input  logic [BC_W-1:0]           fill_idx,
    input  logic [SLOTS*INS_W-1:0]    fill_line,
    input  logic [BC_W-1:0]           rd_idx,
    input  logic [$clog2(SLOTS)-1:0]  rd_slot,
    output logic [INS_W-1:0]          rd_word,
    output logic                      rd_hit
);
    localparam int ENTRIES = 1 << BC_W;
    localparam int LINE_W  = SLOTS * INS_W;

    logic [LINE_W-1:0] line_q [ENTRIES];
    logic [ENTRIES-1:0] vld_q;
    logic [LINE_W-1:0] rd_line;
    logic [INS_W-1:0]  rd_words [SLOTS];

    // Line storage: written only by a fill, no reset needed.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            line_q[fill_idx] <= fill_line;
        end
    end

    // Valid flags: cleared by reset or a set change, set by a fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (clr_all) begin
            vld_q <= '0;
        end else if (fill_en) begin
            vld_q[fill_idx] <= 1'b1;
        end
    end

    assign rd_line = line_q[rd_idx];

    // Split the line into its slot words.
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign rd_words[g] = rd_line[g*INS_W +: INS_W];
    end

    assign rd_word = rd_words[rd_slot];
    assign rd_hit  = vld_q[rd_idx];

endmodule

// File: rtl/btx_fmt.sv
// Module: btx_fmt
// Turns a stored slot word into the word sent to decode. The marker bit
// at MARK_BIT is 0 on the last word of a sequence. It is forced to 1 on
// output, its legal value for a 32-bit encoding. The last slot of a line
// always ends the sequence.
// Assumes: SLOTS is a power of two and at least 2.
module btx_fmt #(
    parameter int SLOTS    = 4,
    parameter int INS_W    = 32,
    parameter int MARK_BIT = 0
) (
    input  logic [INS_W-1:0]          raw_word,
    input  logic [$clog2(SLOTS)-1:0]  slot,
    output logic [INS_W-1:0]          out_word,
    output logic                      seq_end
);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    // Restore the marker bit and decide the end of the sequence.
    always_comb begin
        out_word           = raw_word;
        out_word[MARK_BIT] = 1'b1;
        seq_end            = !raw_word[MARK_BIT] || (slot == LAST_SLOT);
    end

endmodule

// File: rtl/btx_seq.sv
// Module: btx_seq
// Sequencer: accepts a bytecode, fetches its line on a miss, then walks
// the slots. It also holds the set base and the generation tag. A set
// change invalidates the store, bumps the tag, and sends an outstanding
// fill back to the request state. A sequence already issuing keeps going.
// Assumes: entry_hit and seq_end are combinational from the store and
// formatter for the index that the top selects.
module btx_seq
    import btx_pkg::*;
#(
    parameter int BC_W  = 8,
    parameter int SLOTS = 4,
    parameter int GEN_W = 2,
    parameter int SET_W = 20
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bc_valid,
    input  logic [BC_W-1:0]           bc_code,
    input  logic                      cfg_wr,
    input  logic [SET_W-1:0]          cfg_set,
    input  logic                      req_ready,
    input  logic                      rsp_valid,
    input  logic [GEN_W-1:0]          rsp_tag,
    input  logic                      ins_ready,
    input  logic                      entry_hit,
    input  logic                      seq_end,
    output btx_state_e                state_q,
    output logic [BC_W-1:0]           code_q,
    output logic [$clog2(SLOTS)-1:0]  slot_q,
    output logic [GEN_W-1:0]          gen_q,
    output logic [SET_W-1:0]          set_q,
    output logic                      fill_en,
    output logic                      clr_all
);
    localparam int SLOT_W = $clog2(SLOTS);

    btx_state_e state_d;
    logic       accept;
    logic       rsp_match;

    assign accept    = (state_q == ST_IDLE) && bc_valid;
    assign rsp_match = rsp_valid && (rsp_tag == gen_q) && !cfg_wr;
    assign clr_all   = cfg_wr;

    // Next-state decision and fill strobe.
    always_comb begin
        state_d = state_q;
        fill_en = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (bc_valid) begin
                    state_d = entry_hit ? ST_ISSUE : ST_REQ;
                end
            end
            ST_REQ: begin
                if (!cfg_wr && req_ready) begin
                    state_d = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (cfg_wr) begin
                    state_d = ST_REQ;
                end else if (rsp_match) begin
                    fill_en = 1'b1;
                    state_d = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (ins_ready && seq_end) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Bytecode capture and slot counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            slot_q <= '0;
        end else if (accept) begin
            code_q <= bc_code;
            slot_q <= '0;
        end else if ((state_q == ST_ISSUE) && ins_ready && !seq_end) begin
            slot_q <= slot_q + SLOT_W'(1);
        end
    end

    // Set base and generation tag, both updated on a set change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_q <= '0;
            set_q <= '0;
        end else if (cfg_wr) begin
            gen_q <= gen_q + GEN_W'(1);
            set_q <= cfg_set;
        end
    end

endmodule

// File: rtl/bytecode_xlate.sv
// Module: bytecode_xlate (top)
// Reloadable bytecode-to-native translation table. Looks a bytecode up,
// fetches its line of SLOTS words on a miss, and issues the words to
// decode until the marked last one. The fetch address is
// {set base, bytecode, zero byte offset}.
// Assumes: the memory side answers each accepted request once, echoing
// its tag. Responses are taken only while a fill is awaited.
module bytecode_xlate
    import btx_pkg::*;
#(
    parameter int BC_W     = 8,
    parameter int SLOTS    = 4,
    parameter int INS_W    = 32,
    parameter int ADDR_W   = 32,
    parameter int GEN_W    = 2,
    parameter int MARK_BIT = 0
) (
    input  logic                                                  clk,
    input  logic                                                  rst_n,
    input  logic                                                  cfg_wr,
    input  logic [ADDR_W-BC_W-$clog2(SLOTS*INS_W/8)-1:0]          cfg_set,
    input  logic                                                  bc_valid,
    input  logic [BC_W-1:0]                                       bc_code,
    output logic                                                  bc_ready,
    output logic                                                  ins_valid,
    output logic [INS_W-1:0]                                      ins_data,
    output logic                                                  ins_last,
    input  logic                                                  ins_ready,
    output logic                                                  rf_req_valid,
    input  logic                                                  rf_req_ready,
    output logic [ADDR_W-1:0]                                     rf_req_addr,
    output logic [GEN_W-1:0]                                      rf_req_tag,
    input  logic                                                  rf_rsp_valid,
    input  logic [GEN_W-1:0]                                      rf_rsp_tag,
    input  logic [SLOTS*INS_W-1:0]                                rf_rsp_data
);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int OFF_W  = $clog2(SLOTS * INS_W / 8);
    localparam int SET_W  = ADDR_W - BC_W - OFF_W;

    btx_state_e         state_q;
    logic [BC_W-1:0]    code_q;
    logic [SLOT_W-1:0]  slot_q;
    logic [GEN_W-1:0]   gen_q;
    logic [SET_W-1:0]   set_q;
    logic               fill_en;
    logic               clr_all;
    logic [BC_W-1:0]    rd_idx;
    logic [INS_W-1:0]   raw_word;
    logic               entry_hit;
    logic               seq_end;

    // Look up the incoming bytecode while idle, the held one otherwise.
    assign rd_idx = (state_q == ST_IDLE) ? bc_code : code_q;

    btx_store #(
        .BC_W  (BC_W),
        .SLOTS (SLOTS),
        .INS_W (INS_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_all   (clr_all),
        .fill_en   (fill_en),
        .fill_idx  (code_q),
        .fill_line (rf_rsp_data),
        .rd_idx    (rd_idx),
        .rd_slot   (slot_q),
        .rd_word   (raw_word),
        .rd_hit    (entry_hit)
    );

    btx_fmt #(
        .SLOTS    (SLOTS),
        .INS_W    (INS_W),
        .MARK_BIT (MARK_BIT)
    ) u_fmt (
        .raw_word (raw_word),
        .slot     (slot_q),
        .out_word (ins_data),
        .seq_end  (seq_end)
    );

    btx_seq #(
        .BC_W  (BC_W),
        .SLOTS (SLOTS),
        .GEN_W (GEN_W),
        .SET_W (SET_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .bc_valid  (bc_valid),
        .bc_code   (bc_code),
        .cfg_wr    (cfg_wr),
        .cfg_set   (cfg_set),
        .req_ready (rf_req_ready),
        .rsp_valid (rf_rsp_valid),
        .rsp_tag   (rf_rsp_tag),
        .ins_ready (ins_ready),
        .entry_hit (entry_hit),
        .seq_end   (seq_end),
        .state_q   (state_q),
        .code_q    (code_q),
        .slot_q    (slot_q),
        .gen_q     (gen_q),
        .set_q     (set_q),
        .fill_en   (fill_en),
        .clr_all   (clr_all)
    );

    // Handshake flags and the request fields seen at the ports.
    assign bc_ready     = (state_q == ST_IDLE);
    assign ins_valid    = (state_q == ST_ISSUE);
    assign ins_last     = seq_end;
    assign rf_req_valid = (state_q == ST_REQ);
    assign rf_req_addr  = {set_q, code_q, {OFF_W{1'b0}}};
    assign rf_req_tag   = gen_q;

endmodule

// File: rtl/bytecode_xlate_chk.sv
// Module: bytecode_xlate_chk
// Port-level temporal checks of the translation table, attached to every
// bytecode_xlate instance by the bind statement below.
// Assumes: the same parameter values as the instance it is bound to.
module bytecode_xlate_chk #(
    parameter int INS_W    = 32,
    parameter int ADDR_W   = 32,
    parameter int GEN_W    = 2,
    parameter int MARK_BIT = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic              bc_ready,
    input logic              ins_valid,
    input logic [INS_W-1:0]  ins_data,
    input logic              ins_last,
    input logic              ins_ready,
    input logic              rf_req_valid,
    input logic              rf_req_ready,
    input logic [ADDR_W-1:0] rf_req_addr,
    input logic [GEN_W-1:0]  rf_req_tag
);
    AST_NO_ISSUE_DURING_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        !(ins_valid && rf_req_valid));                                             // R2
    AST_FETCH_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        rf_req_valid && rf_req_ready && !cfg_wr |=> !rf_req_valid && !ins_valid);  // R2
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rf_req_valid && !rf_req_ready && !cfg_wr |=>
            rf_req_valid && $stable(rf_req_addr) && $stable(rf_req_tag));          // R3
    AST_CANON_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid |-> ins_data[MARK_BIT]);                                         // R8
    AST_INS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && !ins_ready |=>
            ins_valid && $stable(ins_data) && $stable(ins_last));                  // R9
    AST_LAST_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && ins_ready && ins_last |=> bc_ready);                          // R6
    AST_GEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> rf_req_tag == GEN_W'($past(rf_req_tag) + 1'b1));                // R10
    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        bc_ready |-> !ins_valid && !rf_req_valid);                                 // R13

endmodule

bind bytecode_xlate bytecode_xlate_chk #(
    .INS_W    (INS_W),
    .ADDR_W   (ADDR_W),
    .GEN_W    (GEN_W),
    .MARK_BIT (MARK_BIT)
) u_chk (.*);

// File: tb/bytecode_xlate_test.sv
// Bench: a behavioural reference model, compared on every clock, plus
// directed checks. Inputs change 2 ns after a rising edge. Outputs are
// compared on the falling edge.
module bytecode_xlate_test;
    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic         rst_n = 1'b0;
    logic         cfg_wr = 1'b0;
    logic [19:0]  cfg_set = '0;
    logic         bc_valid = 1'b0;
    logic [7:0]   bc_code = '0;
    logic         bc_ready, ins_valid, ins_last, rf_req_valid;
    logic [31:0]  ins_data, rf_req_addr;
    logic         ins_ready = 1'b1;
    logic         rf_req_ready = 1'b0;
    logic [1:0]   rf_req_tag;
    logic         rf_rsp_valid = 1'b0;
    logic [1:0]   rf_rsp_tag = '0;
    logic [127:0] rf_rsp_data = '0;

    bytecode_xlate uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_set(cfg_set),
        .bc_valid(bc_valid), .bc_code(bc_code), .bc_ready(bc_ready),
        .ins_valid(ins_valid), .ins_data(ins_data), .ins_last(ins_last),
        .ins_ready(ins_ready), .rf_req_valid(rf_req_valid),
        .rf_req_ready(rf_req_ready), .rf_req_addr(rf_req_addr),
        .rf_req_tag(rf_req_tag), .rf_rsp_valid(rf_rsp_valid),
        .rf_rsp_tag(rf_rsp_tag), .rf_rsp_data(rf_rsp_data)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Memory image: marker (bit 0 = 0) on slot code%5, none when code%5==4.
    function automatic logic [127:0] line_for(logic [31:0] a);
        logic [127:0] l;
        for (int s = 0; s < 4; s++) begin
            logic [31:0] h;
            h = a * 32'h9E3779B1 + (s + 1) * 32'h01000193;
            l[s*32 +: 32] = {h[31:2], 1'b1, (s == int'(a[11:4]) % 5) ? 1'b0 : 1'b1};
        end
        return l;
    endfunction

    // ---------------- reference model ----------------
    int          mst, mcode, mslot, mgen;
    logic [19:0] mset;
    bit          mvalid [256];
    logic [31:0] mmem [256][4];
    logic [31:0] mw, cw;

    // Model update on each rising edge from the inputs held at that edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            mst = 0; mcode = 0; mslot = 0; mgen = 0; mset = '0;
            for (int i = 0; i < 256; i++) mvalid[i] = 1'b0;
        end else begin
            case (mst)
                0: if (bc_valid) begin
                       mcode = int'(bc_code); mslot = 0;
                       mst = mvalid[bc_code] ? 3 : 1;
                   end
                1: if (!cfg_wr && rf_req_ready) mst = 2;
                2: if (cfg_wr) mst = 1;
                   else if (rf_rsp_valid && rf_rsp_tag == 2'(mgen)) begin
                       for (int s = 0; s < 4; s++) mmem[mcode][s] = rf_rsp_data[s*32 +: 32];
                       mvalid[mcode] = 1'b1;
                       mst = 3;
                   end
                default: if (ins_ready) begin
                       mw = mmem[mcode][mslot];
                       if (!mw[0] || mslot == 3) mst = 0; else mslot++;
                   end
            endcase
            if (cfg_wr) begin
                for (int i = 0; i < 256; i++) mvalid[i] = 1'b0;
                mgen = (mgen + 1) % 4;
                mset = cfg_set;
            end
        end
    end

    // Compare every output with the model on each falling edge.
    int hs_count = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R13 bc_ready", 64'(bc_ready), 64'(mst == 0));
            chk("R2 rf_req_valid", 64'(rf_req_valid), 64'(mst == 1));
            if (mst == 1) begin
                chk("R2 rf_req_addr", 64'(rf_req_addr), 64'({mset, 8'(mcode), 4'h0}));
                chk("R10 rf_req_tag", 64'(rf_req_tag), 64'(mgen));
            end
            chk("R5 ins_valid", 64'(ins_valid), 64'(mst == 3));
            if (mst == 3) begin
                cw = mmem[mcode][mslot];
                chk("R4/R6 ins_data", 64'(ins_data), 64'(cw | 32'h1));
                chk("R7 ins_last", 64'(ins_last), 64'(!cw[0] || mslot == 3));
                chk("R8 marker bit", 64'(ins_data[0]), 64'd1);
            end
            if (ins_valid && ins_ready) hs_count++;
        end
    end

    // ---------------- memory agent ----------------
    bit           agent_rdy = 1'b1;
    bit           agent_manual = 1'b0;
    int           agent_lat = 1;
    bit           man_fire = 1'b0;
    logic [1:0]   man_tag = '0;
    logic [127:0] man_line = '0;
    logic [33:0]  aq [$];
    logic [33:0]  ae;
    int           acnt = 0;
    int           req_count = 0;

    // Answer accepted requests in order after agent_lat cycles, or inject by hand.
    always @(negedge clk) begin
        rf_rsp_valid = 1'b0;
        if (!rst_n) begin
            aq.delete(); acnt = 0; rf_req_ready = 1'b0;
        end else begin
            if (man_fire) begin
                rf_rsp_valid = 1'b1; rf_rsp_tag = man_tag; rf_rsp_data = man_line;
            end else if (aq.size() > 0) begin
                if (acnt >= agent_lat) begin
                    ae = aq.pop_front();
                    rf_rsp_valid = 1'b1; rf_rsp_tag = ae[1:0];
                    rf_rsp_data = line_for(ae[33:2]); acnt = 0;
                end else acnt++;
            end
            rf_req_ready = agent_rdy;
            if (rf_req_valid && rf_req_ready) begin
                req_count++;
                if (!agent_manual) aq.push_back({rf_req_addr, rf_req_tag});
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic send_bc(logic [7:0] c);
        step(); bc_valid = 1'b1; bc_code = c;
        forever begin @(negedge clk); if (bc_ready) break; end
        step(); bc_valid = 1'b0;
    endtask

    task automatic set_cfg(logic [19:0] v);
        step(); cfg_wr = 1'b1; cfg_set = v;
        step(); cfg_wr = 1'b0;
    endtask

    task automatic wait_idle();
        forever begin @(negedge clk); if (bc_ready) break; end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R13 watchdog actual=hung expected=idle");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    logic [31:0] held_d;
    int          rc0, hs0;

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 bc_ready", 64'(bc_ready), 64'd1);
        chk("R1 ins_valid", 64'(ins_valid), 64'd0);
        chk("R1 rf_req_valid", 64'(rf_req_valid), 64'd0);
        chk("R1 rf_req_tag", 64'(rf_req_tag), 64'd0);

        // R2: first lookup misses and fetches from the set base
        set_cfg(20'h12345);
        send_bc(8'h05);
        @(negedge clk);
        chk("R2 miss request", 64'(rf_req_valid), 64'd1);
        chk("R2 miss address", 64'(rf_req_addr), 64'h12345050);
        wait_idle();

        // R4 R6 R7: fill a sweep of codes with every marker position
        for (int c = 0; c < 10; c++) begin send_bc(8'(c)); wait_idle(); end
        // R5: second pass hits, no refill traffic
        rc0 = req_count;
        for (int c = 0; c < 10; c++) begin send_bc(8'(c)); wait_idle(); end
        chk("R5 no refill on hits", 64'(req_count), 64'(rc0));

        // R3: request held under back-pressure
        agent_rdy = 1'b0;
        send_bc(8'h21);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R3 request held", 64'(rf_req_valid), 64'd1);
            chk("R3 address held", 64'(rf_req_addr), 64'h12345210);
        end
        step(); agent_rdy = 1'b1;
        wait_idle();

        // R9: output held while decode stalls (code 9 has no marker)
        ins_ready = 1'b0;
        send_bc(8'h09);
        @(negedge clk); held_d = ins_data;
        repeat (3) begin
            @(negedge clk);
            chk("R9 ins_data held", 64'(ins_data), 64'(held_d));
        end
        step(); ins_ready = 1'b1;
        wait_idle();

        // R12: set change during issue; all four slots still arrive
        ins_ready = 1'b0;
        hs0 = hs_count;
        send_bc(8'h09);
        set_cfg(20'hABCDE);
        step(); ins_ready = 1'b1;
        wait_idle();
        chk("R12 slots after set change", 64'(hs_count - hs0), 64'd4);

        // R10: former hit now misses at the new base with the new tag
        send_bc(8'h03);
        @(negedge clk);
        chk("R10 miss after set change", 64'(rf_req_valid), 64'd1);
        chk("R10 new base", 64'(rf_req_addr), 64'hABCDE030);
        chk("R10 new tag", 64'(rf_req_tag), 64'd2);
        wait_idle();

        // R11: stale-tag response dropped
        agent_manual = 1'b1;
        send_bc(8'h40);
        step();
        man_fire = 1'b1; man_tag = 2'd3; man_line = line_for(32'hABCDE400);
        step(); man_fire = 1'b0;
        @(negedge clk);
        chk("R11 stale tag ignored", 64'(ins_valid), 64'd0);
        step();
        man_fire = 1'b1; man_tag = 2'd2;
        step(); man_fire = 1'b0;
        wait_idle();

        // R11: response and set change in the same cycle
        send_bc(8'h41);
        step();
        man_fire = 1'b1; man_tag = 2'd2; man_line = line_for(32'hABCDE410);
        cfg_wr = 1'b1; cfg_set = 20'h00777;
        step(); man_fire = 1'b0; cfg_wr = 1'b0;
        @(negedge clk);
        chk("R11 fill dropped, request again", 64'(rf_req_valid), 64'd1);
        chk("R11 re-request tag", 64'(rf_req_tag), 64'd3);
        chk("R11 re-request base", 64'(rf_req_addr), 64'h00777410);
        chk("R11 no issue", 64'(ins_valid), 64'd0);
        agent_manual = 1'b0;
        wait_idle();

        // R13: long refill latency, ready stays low until done
        agent_lat = 5;
        send_bc(8'h80);
        @(negedge clk);
        chk("R13 busy during refill", 64'(bc_ready), 64'd0);
        wait_idle();

        repeat (4) step();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule